// File: doc/BRIEF.md
# Multi-Block Disk Address Sequencer

This block tracks the cylinder, head and sector of a disk transfer that spans several blocks. A transfer is opened with a start strobe carrying the first address, the number of blocks and a sector-size code. The block checks that address against the drive limits that were programmed earlier. A bad address is refused before any block moves. An accepted address is loaded as the current address. If the heads are not already on the target cylinder, a seek request is raised. When the positioner reports that the seek has finished, a one-cycle cylinder-verify strobe follows, and the transfer window then opens.

While the window is open, each block-done strobe uses up one block and moves the address forward. The sector advances within a track. At the end of a track the next head on the same cylinder is taken. After the last head of a cylinder the block moves to the next cylinder, resets the head to 0 and issues a new seek before the run continues. The number of sectors per track comes from the sector-size code. The run ends with a done flag when the block count is used up. It ends with an error flag if the address would step past the last cylinder.

Top module: `disk_addr_seq`

## Requirements
- R1: The sector-size code sets the sectors per track: code 0 gives 33 (256-byte sectors), code 1 gives 18 (512-byte), code 2 gives 9 (1024-byte), and code 3 is refused as out of range.
- R2: Inside a track, each accepted block-done strobe adds one to the sector number and keeps the head and cylinder.
- R3: A block-done strobe on the last sector of a track sets the sector to 0 and moves to the next head on the same cylinder.
- R4: A block-done strobe on the last sector of the last head sets the sector and head to 0 and moves to the next cylinder. The seek request is then raised, and no further block is accepted until the seek completes.
- R5: A start is refused, with the error flag set and no busy, seek or transfer window, when any of these holds: the cylinder is above the programmed last cylinder, the head is above the programmed last head, the sector is not below the sectors per track, or the code is 3.
- R6: An accepted start raises the seek request only when its cylinder differs from the cylinder the heads were last positioned on (0 after reset). The request stays high until the seek-complete input is seen.
- R7: The cycle after seek completion, the verify output is high for exactly one cycle. The transfer window opens in the cycle after that.
- R8: If a block must step past the last sector, last head and last cylinder while blocks remain, the run stops with the error flag set and accepts no further blocks. If the final block of the count lands exactly at the end of the drive, the run ends with done and no error.
- R9: Each accepted block-done strobe counts down the block count. Done is raised when the count reaches zero. A start with a count of 0 and a valid address raises done at once and opens no transfer window.
- R10: The last-cylinder and last-head limits reset to 305 and 3. A configuration write changes them only while the block is idle.
- R11: A block-done strobe outside the transfer window does not change the address. A start strobe during a run is ignored.
- R12: After reset the busy, window, seek, verify, done and error outputs are low and the current address is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Limit write strobe (honoured when idle) |
| cfg_last_cyl | input | CYL_W | Highest valid cylinder |
| cfg_last_head | input | HEAD_W | Highest valid head |
| start | input | 1 | Open a run with the start fields below |
| start_cyl | input | CYL_W | First cylinder |
| start_head | input | HEAD_W | First head |
| start_sec | input | 6 | First sector (0-based) |
| start_count | input | CNT_W | Number of blocks |
| size_code | input | 2 | Sector-size code |
| blk_done | input | 1 | One block finished |
| seek_done | input | 1 | Positioner finished the requested seek |
| busy | output | 1 | A run is in progress |
| active | output | 1 | Transfer window open, blocks accepted |
| seek_req | output | 1 | Seek to the current cylinder requested |
| verify | output | 1 | One-cycle cylinder-verify strobe |
| cur_cyl | output | CYL_W | Current cylinder |
| cur_head | output | HEAD_W | Current head |
| cur_sec | output | 6 | Current sector |
| done | output | 1 | Last run completed its count |
| err | output | 1 | Last run refused or ran past the drive end |

## Verification
Some behaviour is checked by assertions on every cycle. A seek request never overlaps the transfer window, and it holds until completion. The verify strobe lasts one cycle and is followed by the window. The current address stays inside the limits during a run. Done and error never appear together. The limits hold unless a write arrives while idle, and idle block strobes leave the address alone.

The exact address order needs the bench's scenarios. This covers the rollover at the end of a track and of a cylinder under each sector-size code, the count of seeks per run, the refusal cases, and the two ways a run can meet the end of the drive.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int SEC_W = 6;

  typedef enum logic [1:0] {
    GEO_256 = 2'd0,
    GEO_512 = 2'd1,
    GEO_1K  = 2'd2,
    GEO_BAD = 2'd3
  } geo_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_VERIFY,
    ST_XFER
  } seq_st_e;

  // Highest sector index of a track for a size code (0 for the refused code).
  function automatic logic [SEC_W-1:0] last_sector(input logic [1:0] code);
    logic [SEC_W-1:0] r;
    case (geo_e'(code))
      GEO_256: r = SEC_W'(32);
      GEO_512: r = SEC_W'(17);
      GEO_1K:  r = SEC_W'(8);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dseq_limits.sv
module dseq_limits #(
  parameter int CYL_W         = 10,
  parameter int HEAD_W        = 3,
  parameter int DEF_LAST_CYL  = 305,
  parameter int DEF_LAST_HEAD = 3
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [CYL_W-1:0]  new_cyl,
  input  logic [HEAD_W-1:0] new_head,
  output logic [CYL_W-1:0]  lim_cyl,
  output logic [HEAD_W-1:0] lim_head
);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_cyl  <= CYL_W'(DEF_LAST_CYL);
      lim_head <= HEAD_W'(DEF_LAST_HEAD);
    end else if (load) begin
      lim_cyl  <= new_cyl;
      lim_head <= new_head;
    end
  end

  // R10: limits move only on a permitted load
  p_lim_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !load |=> ($stable(lim_cyl) && $stable(lim_head)));

endmodule

// File: rtl/dseq_range_chk.sv
module dseq_range_chk
  import dseq_pkg::*;
#(
  parameter int CYL_W  = 10,
  parameter int HEAD_W = 3
) (
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W-1:0] head,
  input  logic [SEC_W-1:0]  sec,
  input  logic [1:0]        code,
  input  logic [CYL_W-1:0]  lim_cyl,
  input  logic [HEAD_W-1:0] lim_head,
  output logic [SEC_W-1:0]  sec_last,
  output logic              in_range
);

  logic code_ok, cyl_ok, head_ok, sec_ok;

  always_comb begin
    sec_last = last_sector(code);
    code_ok  = (geo_e'(code) != GEO_BAD);
    cyl_ok   = (cyl <= lim_cyl);
    head_ok  = (head <= lim_head);
    sec_ok   = (sec <= sec_last);
    in_range = code_ok && cyl_ok && head_ok && sec_ok;
  end

endmodule

// File: rtl/dseq_stepper.sv
module dseq_stepper
  import dseq_pkg::*;
#(
  parameter int CYL_W  = 10,
  parameter int HEAD_W = 3
) (
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W-1:0] head,
  input  logic [SEC_W-1:0]  sec,
  input  logic [CYL_W-1:0]  lim_cyl,
  input  logic [HEAD_W-1:0] lim_head,
  input  logic [SEC_W-1:0]  sec_last,
  output logic [CYL_W-1:0]  nxt_cyl,
  output logic [HEAD_W-1:0] nxt_head,
  output logic [SEC_W-1:0]  nxt_sec,
  output logic              cyl_move,
  output logic              past_end
);

  always_comb begin
    nxt_cyl  = cyl;
    nxt_head = head;
    nxt_sec  = sec;
    cyl_move = 1'b0;
    past_end = 1'b0;
    if (sec != sec_last) begin
      nxt_sec = sec + 1'b1;
    end else begin
      nxt_sec = '0;
      if (head != lim_head) begin
        nxt_head = head + 1'b1;
      end else begin
        nxt_head = '0;
        if (cyl != lim_cyl) begin
          nxt_cyl  = cyl + 1'b1;
          cyl_move = 1'b1;
        end else begin
          past_end = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/disk_addr_seq.sv
module disk_addr_seq
  import dseq_pkg::*;
#(
  parameter int CYL_W         = 10,
  parameter int HEAD_W        = 3,
  parameter int CNT_W         = 8,
  parameter int DEF_LAST_CYL  = 305,
  parameter int DEF_LAST_HEAD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CYL_W-1:0]  cfg_last_cyl,
  input  logic [HEAD_W-1:0] cfg_last_head,
  input  logic              start,
  input  logic [CYL_W-1:0]  start_cyl,
  input  logic [HEAD_W-1:0] start_head,
  input  logic [5:0]        start_sec,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [1:0]        size_code,
  input  logic              blk_done,
  input  logic              seek_done,
  output logic              busy,
  output logic              active,
  output logic              seek_req,
  output logic              verify,
  output logic [CYL_W-1:0]  cur_cyl,
  output logic [HEAD_W-1:0] cur_head,
  output logic [5:0]        cur_sec,
  output logic              done,
  output logic              err
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  seq_st_e           st_q, st_d;
  logic [CYL_W-1:0]  cyl_q, pos_q, lim_cyl, nxt_cyl;
  logic [HEAD_W-1:0] head_q, lim_head, nxt_head;
  logic [SEC_W-1:0]  sec_q, lsec_q, nxt_sec, start_last;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              done_q, done_d, err_q, err_d;
  logic              start_ok, cyl_move, past_end;
  logic              addr_ld, addr_step, pos_ld, cfg_ld, last_blk;

  assign cfg_ld = cfg_we && (st_q == ST_IDLE);

  dseq_limits #(
    .CYL_W(CYL_W), .HEAD_W(HEAD_W),
    .DEF_LAST_CYL(DEF_LAST_CYL), .DEF_LAST_HEAD(DEF_LAST_HEAD)
  ) u_lim (
    .clk(clk), .rst_ni(rst_ni), .load(cfg_ld),
    .new_cyl(cfg_last_cyl), .new_head(cfg_last_head),
    .lim_cyl(lim_cyl), .lim_head(lim_head)
  );

  dseq_range_chk #(.CYL_W(CYL_W), .HEAD_W(HEAD_W)) u_chk (
    .cyl(start_cyl), .head(start_head), .sec(start_sec), .code(size_code),
    .lim_cyl(lim_cyl), .lim_head(lim_head),
    .sec_last(start_last), .in_range(start_ok)
  );

  dseq_stepper #(.CYL_W(CYL_W), .HEAD_W(HEAD_W)) u_step (
    .cyl(cyl_q), .head(head_q), .sec(sec_q),
    .lim_cyl(lim_cyl), .lim_head(lim_head), .sec_last(lsec_q),
    .nxt_cyl(nxt_cyl), .nxt_head(nxt_head), .nxt_sec(nxt_sec),
    .cyl_move(cyl_move), .past_end(past_end)
  );

  // clock enables
  assign last_blk  = (left_q == CNT_W'(1));
  assign addr_ld   = (st_q == ST_IDLE) && start && start_ok && (start_count != '0);
  assign addr_step = (st_q == ST_XFER) && blk_done && !last_blk && !past_end;
  assign pos_ld    = (st_q == ST_SEEK) && seek_done;

  // next state
  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    done_d = done_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          done_d = 1'b0;
          err_d  = 1'b0;
          if (!start_ok) begin
            err_d = 1'b1;
          end else if (start_count == '0) begin
            done_d = 1'b1;
          end else begin
            left_d = start_count;
            st_d   = (start_cyl != pos_q) ? ST_SEEK : ST_XFER;
          end
        end
      end
      ST_SEEK: begin
        if (seek_done) st_d = ST_VERIFY;
      end
      ST_VERIFY: begin
        st_d = ST_XFER;
      end
      ST_XFER: begin
        if (blk_done) begin
          left_d = left_q - 1'b1;
          if (last_blk) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (past_end) begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            st_d = cyl_move ? ST_SEEK : ST_XFER;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_q  <= '0;
      head_q <= '0;
      sec_q  <= '0;
      lsec_q <= '0;
    end else if (addr_ld) begin
      cyl_q  <= start_cyl;
      head_q <= start_head;
      sec_q  <= start_sec;
      lsec_q <= start_last;
    end else if (addr_step) begin
      cyl_q  <= nxt_cyl;
      head_q <= nxt_head;
      sec_q  <= nxt_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (pos_ld) pos_q <= cyl_q;
  end

  assign busy     = (st_q != ST_IDLE);
  assign active   = (st_q == ST_XFER);
  assign seek_req = (st_q == ST_SEEK);
  assign verify   = (st_q == ST_VERIFY);
  assign cur_cyl  = cyl_q;
  assign cur_head = head_q;
  assign cur_sec  = sec_q;
  assign done     = done_q;
  assign err      = err_q;

  // R4: no block window while a seek is outstanding
  p_seek_no_xfer_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    seek_req |-> !active);

  // R6: seek request held until completion
  p_seek_hold_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (seek_req && !seek_done) |=> seek_req);

  // R7: completion leads to verify, verify lasts one cycle then window
  p_seek_to_verify_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (seek_req && seek_done) |=> verify);
  p_verify_once_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    verify |=> (active && !verify));

  // R5: address stays within the limits during a run
  p_addr_bound_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (cur_cyl <= lim_cyl && cur_head <= lim_head && cur_sec <= lsec_q));

  // R8: a run never reports both outcomes
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !(done && err));

  // R11: strobes outside the window leave the address alone
  p_idle_blk_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!active && blk_done && !(start && !busy))
      |=> ($stable(cur_cyl) && $stable(cur_head) && $stable(cur_sec)));

endmodule

// File: tb/disk_addr_seq_test.sv
module disk_addr_seq_test;

  localparam int CYL_W  = 10;
  localparam int HEAD_W = 3;
  localparam int CNT_W  = 8;

  typedef struct {
    int    c;
    int    h;
    int    s;
    string tag;
  } blk_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CYL_W-1:0]  cfg_last_cyl = '0;
  logic [HEAD_W-1:0] cfg_last_head = '0;
  logic              start = 1'b0;
  logic [CYL_W-1:0]  start_cyl = '0;
  logic [HEAD_W-1:0] start_head = '0;
  logic [5:0]        start_sec = '0;
  logic [CNT_W-1:0]  start_count = '0;
  logic [1:0]        size_code = '0;
  logic              blk_done = 1'b0;
  logic              seek_done = 1'b0;
  logic              busy, active, seek_req, verify, done, err;
  logic [CYL_W-1:0]  cur_cyl;
  logic [HEAD_W-1:0] cur_head;
  logic [5:0]        cur_sec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  blk_t exp_q[$];

  // bench-side model state
  int m_lc = 305, m_lh = 3, m_pos = 0;
  int m_lastc = 0, m_lasth = 0, m_lasts = 0;

  disk_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_last_cyl(cfg_last_cyl),
    .cfg_last_head(cfg_last_head), .start(start), .start_cyl(start_cyl),
    .start_head(start_head), .start_sec(start_sec), .start_count(start_count),
    .size_code(size_code), .blk_done(blk_done), .seek_done(seek_done),
    .busy(busy), .active(active), .seek_req(seek_req), .verify(verify),
    .cur_cyl(cur_cyl), .cur_head(cur_head), .cur_sec(cur_sec),
    .done(done), .err(err)
  );

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: compares each accepted block address against the scoreboard
  always @(negedge clk) begin
    if (rst_n && blk_done && active) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected block accepted", 1, 0);
      end else begin
        blk_t it;
        it = exp_q.pop_front();
        chk(int'(cur_cyl) == it.c && int'(cur_head) == it.h && int'(cur_sec) == it.s,
            it.tag, "block address c*10000+h*100+s",
            int'(cur_cyl) * 10000 + int'(cur_head) * 100 + int'(cur_sec),
            it.c * 10000 + it.h * 100 + it.s);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // driver: models the run, fills the scoreboard, then drives it
  task automatic run(int c, int h, int s, int n, int code, bit poke, string tag);
    int spt, seeks, cc, hh, ss, got_seeks, got_ver, wcnt, guard;
    bit ok, e_err, e_done, prev_seek, poked;
    spt = (code == 0) ? 33 : (code == 1) ? 18 : (code == 2) ? 9 : 0;
    ok = (code != 3) && c <= m_lc && h <= m_lh && s < spt;
    seeks = 0; e_err = 0; e_done = 0;
    cc = c; hh = h; ss = s;
    if (!ok) e_err = 1;
    else if (n == 0) e_done = 1;
    else begin
      if (cc != m_pos) seeks++;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back('{c: cc, h: hh, s: ss, tag: tag});
        m_pos = cc; m_lastc = cc; m_lasth = hh; m_lasts = ss;
        if (k == n - 1) begin e_done = 1; break; end
        if (ss < spt - 1) ss++;
        else begin
          ss = 0;
          if (hh < m_lh) hh++;
          else begin
            hh = 0;
            if (cc < m_lc) begin cc++; seeks++; end
            else begin e_err = 1; break; end
          end
        end
      end
    end

    @(posedge clk); #1;
    start = 1'b1;
    start_cyl = CYL_W'(c); start_head = HEAD_W'(h); start_sec = 6'(s);
    start_count = CNT_W'(n); size_code = 2'(code);
    got_seeks = 0; got_ver = 0; wcnt = 0; prev_seek = 0; poked = 0; guard = 0;
    while (guard < 2000) begin
      guard++;
      @(posedge clk); #1;
      start = 1'b0; cfg_we = 1'b0;
      if (seek_req && !prev_seek) got_seeks++;
      prev_seek = seek_req;
      if (verify) got_ver++;
      if (seek_req) begin
        wcnt++;
        seek_done = (wcnt == 3);
      end else begin
        wcnt = 0;
        seek_done = 1'b0;
      end
      if (poke && active && !poked) begin
        // R11 / R10: start and limit write during a run must be ignored
        start = 1'b1; start_cyl = '0; start_head = '0; start_sec = '0;
        start_count = CNT_W'(1);
        cfg_we = 1'b1; cfg_last_cyl = '0; cfg_last_head = '0;
        poked = 1;
      end
      blk_done = active;
      if (!busy) break;
    end
    blk_done = 1'b0; seek_done = 1'b0; start = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, tag, "blocks left unissued", exp_q.size(), 0);
    chk(err == e_err, tag, "error flag", int'(err), int'(e_err));
    chk(done == e_done, tag, "done flag", int'(done), int'(e_done));
    chk(got_seeks == seeks, (seeks > 0) ? "R6" : tag, "seek count", got_seeks, seeks);
    chk(got_ver == seeks, "R7", "verify pulses", got_ver, seeks);
    chk(!busy && !active, tag, "idle after run", int'(busy), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(!busy && !active && !seek_req && !verify, "R12", "control outputs", int'(busy), 0);
    chk(!done && !err, "R12", "flags", int'(done) + int'(err), 0);
    chk(cur_cyl == 0 && cur_head == 0 && cur_sec == 0, "R12", "address",
        int'(cur_cyl) + int'(cur_head) + int'(cur_sec), 0);

    // R10: default limits 305 / 3
    run(305, 3, 0, 1, 2, 0, "R10");
    run(306, 0, 0, 1, 2, 0, "R10");
    run(0, 4, 0, 1, 2, 0, "R10");

    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_last_cyl = CYL_W'(5); cfg_last_head = HEAD_W'(1);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_lc = 5; m_lh = 1;

    run(0, 0, 7, 4, 2, 0, "R3");      // R2 then R3 rollover, seek from 305
    run(0, 1, 8, 3, 2, 0, "R4");      // cylinder rollover with seek
    run(1, 0, 31, 3, 0, 0, "R1");     // 33-sector track
    run(1, 0, 17, 2, 1, 0, "R1");     // 18-sector track
    run(1, 0, 18, 1, 1, 0, "R5");     // sector beyond 18-sector track
    run(1, 0, 9, 1, 2, 0, "R5");      // sector beyond 9-sector track
    run(0, 0, 0, 1, 3, 0, "R1");      // refused code
    run(6, 0, 0, 1, 2, 0, "R5");
    run(0, 2, 0, 1, 2, 0, "R5");
    run(2, 0, 0, 5, 2, 0, "R2");      // plain sector advance with seek
    run(5, 1, 8, 3, 2, 0, "R8");      // runs off the end
    run(5, 1, 8, 1, 2, 0, "R8");      // ends exactly at the end
    run(2, 0, 0, 0, 2, 0, "R9");      // zero count
    chk(cur_cyl == 5 && cur_head == 1 && cur_sec == 8, "R9", "address after zero count",
        int'(cur_cyl) * 10000 + int'(cur_head) * 100 + int'(cur_sec), 50108);
    run(3, 1, 5, 2, 2, 1, "R11");     // start and cfg poked mid-run
    run(5, 0, 0, 1, 2, 0, "R10");     // limit write while busy did not land

    // R11: block strobes while idle
    @(posedge clk); #1;
    blk_done = 1'b1;
    repeat (3) @(posedge clk);
    #1 blk_done = 1'b0;
    @(negedge clk);
    chk(int'(cur_cyl) == m_lastc && int'(cur_head) == m_lasth && int'(cur_sec) == m_lasts,
        "R11", "address after idle strobes",
        int'(cur_cyl) * 10000 + int'(cur_head) * 100 + int'(cur_sec),
        m_lastc * 10000 + m_lasth * 100 + m_lasts);
    chk(!busy, "R11", "still idle", int'(busy), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule